// File: doc/BRIEF.md
# Pipelined Reciprocal-Square Taylor Divider

This block divides one normalized significand by another. Both operands are unsigned fixed-point words of 2M bits with one integer bit and 2M-1 fraction bits, so each holds a value in [1,2). The quotient comes back in the same format, one result per clock, after a fixed pipeline delay. A valid flag travels with each operand pair. Sign, exponent, normalization of quotients below one, rounding modes and exception handling are left to the surrounding floating-point stages.

The divisor is cut into a high part and a low part. The high part holds the leading one and the next M bits, and the low part holds the remaining M-1 bits. The expansion point is the midpoint of the high part's segment, so the low remainder is a signed offset no larger than 2^-(M+1). A first multiplier forms the dividend times (2·midpoint − divisor), which equals X·(Yh − Yl). A synchronously read table holds 1/Yh² for all 2^M segments and is filled at elaboration from the parameters. A second multiplier scales the first product by the table word. A final round-to-nearest with saturation gives the 2M-bit quotient. Before that final rounding, the first-order approximation is within half an ulp of the exact quotient.

Top module: `tdiv_taylor_divider`

## Requirements
- R1: Operands and quotient are 2M-bit unsigned words with one integer bit (bit 2M-1) and 2M-1 fraction bits. For operands in [1,2), every valid quotient lies in [0.5,2), so its word is at least 2^(2M-2).
- R2: Every valid quotient Q differs from the exact quotient X/Y by less than one unit in the last place, i.e. |Q·Y − X·2^(2M-1)| < Y in integer terms.
- R3: When the exact quotient is representable, it is returned exactly. This covers equal operands (result 2^(2M-1), i.e. 1.0) and a divisor of exactly 1.0 (result equal to the dividend).
- R4: Latency is exactly 5 clocks. An operand pair presented with in_valid high at clock edge k appears on quotient with out_valid high after edge k+4. A new pair is accepted on every clock.
- R5: out_valid follows in_valid delayed by 5 clocks. A clock with in_valid low produces exactly one output slot with out_valid low.
- R6: A synchronous active-high reset clears every valid stage. out_valid is low for the 5 clocks after reset is released, unless it is set by pairs presented after the release. Pairs in flight when reset is asserted never emerge.
- R7: The accuracy bound of R2 holds at both ends of every divisor segment, that is, with the divisor's low M-1 bits all zeros or all ones, for each of the 2^M high-part values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operand pair on this clock is to be divided |
| dividend | input | 2M | Dividend X, value in [1,2), 2M-1 fraction bits |
| divisor | input | 2M | Divisor Y, value in [1,2), 2M-1 fraction bits |
| out_valid | output | 1 | quotient carries a result |
| quotient | output | 2M | Quotient X/Y, value in [0.5,2), 2M-1 fraction bits |

## Verification
A wrong table word or a wrong divisor split shows up as a quotient error of one ulp or more. It appears only for divisors in the affected segment, so the bench covers both ends of every segment as well as random operands, and a bad word is exposed five clocks after the first divisor that reaches it. A mistimed or uncleared valid stage shows up as a valid flag that is early, late or missing relative to the reference delay line. It is seen on the very next output slot, and a mid-stream reset confirms that no stale result escapes.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;

  // Rounded table word for segment idx: 2^tw / Yh^2, where the segment
  // midpoint is Yh = (2^(m+1) + 2*idx + 1) / 2^(m+1).
  function automatic logic [127:0] recip_sq_word(input int unsigned idx,
                                                 input int unsigned m,
                                                 input int unsigned tw);
    logic [127:0] h;
    logic [127:0] hsq;
    logic [127:0] num;
    h   = (128'd1 << (m + 1)) + 128'(2 * idx + 1);
    hsq = h * h;
    num = (128'd1 << (tw + 2 * m + 2)) + (hsq >> 1);
    return num / hsq;
  endfunction

endpackage

// File: rtl/tdiv_split.sv
module tdiv_split #(
  parameter int M = 8
) (
  input  logic [2*M-1:0] y,
  output logic [2*M:0]   d,
  output logic [M-1:0]   idx
);
  localparam int W  = 2 * M;
  localparam int LO = M - 1;

  logic [W-1:0] y_mid;

  // segment midpoint: keep high part, low part set to half its range
  assign y_mid = {y[W-1:LO], 1'b1, {(LO-1){1'b0}}};
  // Yh - Yl with Yl = y - y_mid, i.e. 2*y_mid - y
  assign d     = {y_mid, 1'b0} - {1'b0, y};
  assign idx   = y[W-2:LO];
endmodule

// File: rtl/tdiv_recip_rom.sv
module tdiv_recip_rom #(
  parameter int M  = 8,
  parameter int TW = 21
) (
  input  logic          clk,
  input  logic [M-1:0]  addr,
  output logic [TW-1:0] data
);
  localparam int DEPTH = 1 << M;

  logic [TW-1:0] rom_q [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom_q[i] = TW'(tdiv_pkg::recip_sq_word(i, M, TW));
    end
  end

  always_ff @(posedge clk) begin
    data <= rom_q[addr];
  end
endmodule

// File: rtl/tdiv_mul_reg.sv
module tdiv_mul_reg #(
  parameter int AW = 16,
  parameter int BW = 17
) (
  input  logic             clk,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);
  localparam int PW = AW + BW;

  always_ff @(posedge clk) begin
    p <= PW'(a) * PW'(b);
  end
endmodule

// File: rtl/tdiv_round_sat.sv
module tdiv_round_sat #(
  parameter int IW   = 33,
  parameter int DROP = 11,
  parameter int OW   = 21
) (
  input  logic [IW-1:0] din,
  output logic [OW-1:0] dout
);
  localparam int SW = IW - DROP + 1;
  localparam logic [IW:0] HALF = (IW+1)'(1) << (DROP - 1);

  logic [IW:0]   sum;
  logic [SW-1:0] sh;

  assign sum = {1'b0, din} + HALF;
  assign sh  = SW'(sum >> DROP);

  generate
    if (SW > OW) begin : g_sat
      assign dout = (|sh[SW-1:OW]) ? {OW{1'b1}} : sh[OW-1:0];
    end else begin : g_fit
      assign dout = OW'(sh);
    end
  endgenerate
endmodule

// File: rtl/tdiv_taylor_divider.sv
module tdiv_taylor_divider #(
  parameter int M     = 8,
  parameter int GUARD = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2*M-1:0] dividend,
  input  logic [2*M-1:0] divisor,
  output logic         out_valid,
  output logic [2*M-1:0] quotient
);
  localparam int W    = 2 * M;
  localparam int F    = W - 1;
  localparam int DW   = W + 1;
  localparam int TW   = W + 2 + GUARD;
  localparam int P1W  = W + DW;
  localparam int P1D  = F - 1 - GUARD;
  localparam int PRW  = W + 2 + GUARD;
  localparam int P2W  = PRW + TW;
  localparam int P2D  = W + 3 + 2 * GUARD;
  localparam int LAT  = 5;

  // stage 1: split divisor, register operands
  logic [DW-1:0]  d_c;
  logic [M-1:0]   idx_c;
  logic [W-1:0]   x1;
  logic [DW-1:0]  d1;
  logic [M-1:0]   idx1;

  tdiv_split #(.M(M)) u_split (
    .y   (divisor),
    .d   (d_c),
    .idx (idx_c)
  );

  always_ff @(posedge clk) begin
    x1   <= dividend;
    d1   <= d_c;
    idx1 <= idx_c;
  end

  // stage 2: first product and table read in parallel
  logic [P1W-1:0] p1_2;
  logic [TW-1:0]  t2;

  tdiv_mul_reg #(.AW(W), .BW(DW)) u_mul1 (
    .clk (clk),
    .a   (x1),
    .b   (d1),
    .p   (p1_2)
  );

  tdiv_recip_rom #(.M(M), .TW(TW)) u_rom (
    .clk  (clk),
    .addr (idx1),
    .data (t2)
  );

  // stage 3: round first product to its working width
  logic [PRW-1:0] p1r_c;
  logic [PRW-1:0] p1r3;
  logic [TW-1:0]  t3;

  tdiv_round_sat #(.IW(P1W), .DROP(P1D), .OW(PRW)) u_rnd1 (
    .din  (p1_2),
    .dout (p1r_c)
  );

  always_ff @(posedge clk) begin
    p1r3 <= p1r_c;
    t3   <= t2;
  end

  // stage 4: scale by reciprocal square
  logic [P2W-1:0] p2_4;

  tdiv_mul_reg #(.AW(PRW), .BW(TW)) u_mul2 (
    .clk (clk),
    .a   (p1r3),
    .b   (t3),
    .p   (p2_4)
  );

  // stage 5: final round to nearest with saturation
  logic [W-1:0] q_c;

  tdiv_round_sat #(.IW(P2W), .DROP(P2D), .OW(W)) u_rnd2 (
    .din  (p2_4),
    .dout (q_c)
  );

  always_ff @(posedge clk) begin
    quotient <= q_c;
  end

  // valid delay line, cleared by reset
  logic [LAT-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      vld <= {vld[LAT-2:0], in_valid};
    end
  end

  assign out_valid = vld[LAT-1];
endmodule

// File: rtl/tdiv_taylor_divider_chk.sv
module tdiv_taylor_divider_chk #(
  parameter int M = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [2*M-1:0] dividend,
  input logic [2*M-1:0] divisor,
  input logic           out_valid,
  input logic [2*M-1:0] quotient
);
  localparam int W   = 2 * M;
  localparam int F   = W - 1;
  localparam int LAT = 5;
  localparam logic [W-1:0] ONE   = W'(1) << F;
  localparam logic [W-1:0] HALFQ = W'(1) << (F - 1);

  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
    end else if (since_rst != 3'(LAT)) begin
      since_rst <= since_rst + 3'd1;
    end
  end

  // R6
  no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'(LAT)) |-> !out_valid);

  // R4
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

  // R1
  quot_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (quotient >= HALFQ));

  // R3
  equal_ops_chk: assert property (@(posedge clk) disable iff (rst)
    ((since_rst == 3'(LAT)) && out_valid && $past(dividend == divisor, LAT))
    |-> (quotient == ONE));

  // R3
  unit_divisor_chk: assert property (@(posedge clk) disable iff (rst)
    ((since_rst == 3'(LAT)) && out_valid && $past(divisor == ONE, LAT))
    |-> (quotient == $past(dividend, LAT)));
endmodule

bind tdiv_taylor_divider tdiv_taylor_divider_chk #(.M(M)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .dividend  (dividend),
  .divisor   (divisor),
  .out_valid (out_valid),
  .quotient  (quotient)
);

// File: tb/tb_tdiv_taylor_divider.sv
module tb_tdiv_taylor_divider;
  localparam int CLK_PERIOD = 10;
  localparam int M   = 8;
  localparam int W   = 2 * M;
  localparam int F   = W - 1;
  localparam int LAT = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         out_valid;
  logic [W-1:0] quotient;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdiv_taylor_divider #(.M(M), .GUARD(3)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dividend  (dividend),
    .divisor   (divisor),
    .out_valid (out_valid),
    .quotient  (quotient)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference: delay line of expected slots
  bit           mv [LAT];
  logic [W-1:0] mx [LAT];
  logic [W-1:0] my [LAT];
  string        mt [LAT];
  string        vtag = "R6";

  task automatic check_out();
    longint e;
    longint qx;
    n_cmp++;
    if (out_valid !== mv[LAT-1]) begin
      n_bad++;
      $display("FAIL %s out_valid: actual %b expected %b", vtag, out_valid, mv[LAT-1]);
    end
    if (mv[LAT-1]) begin
      n_cmp++;
      if (quotient < (W'(1) << (F - 1))) begin
        n_bad++;
        $display("FAIL R1 range: actual %h expected >= %h", quotient, W'(1) << (F - 1));
      end
      if (mt[LAT-1] == "R3") begin
        qx = (longint'(mx[LAT-1]) << F) / longint'(my[LAT-1]);
        n_cmp++;
        if (longint'(quotient) != qx) begin
          n_bad++;
          $display("FAIL R3 exact %h/%h: actual %h expected %h",
                   mx[LAT-1], my[LAT-1], quotient, qx);
        end
      end else begin
        e = longint'(quotient) * longint'(my[LAT-1]) - (longint'(mx[LAT-1]) << F);
        if (e < 0) e = -e;
        n_cmp++;
        if (e >= longint'(my[LAT-1])) begin
          n_bad++;
          $display("FAIL %s accuracy %h/%h: actual %h error*Y %0d expected < %0d",
                   mt[LAT-1], mx[LAT-1], my[LAT-1], quotient, e, my[LAT-1]);
        end
      end
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] x, input logic [W-1:0] y,
                      input string tag, input bit r);
    rst = r;
    in_valid = v;
    dividend = x;
    divisor = y;
    @(posedge clk);
    for (int i = LAT - 1; i > 0; i--) begin
      mv[i] = mv[i-1];
      mx[i] = mx[i-1];
      my[i] = my[i-1];
      mt[i] = mt[i-1];
    end
    mv[0] = v && !r;
    mx[0] = x;
    my[0] = y;
    mt[0] = tag;
    if (r) begin
      for (int i = 0; i < LAT; i++) mv[i] = 1'b0;
    end
    @(negedge clk);
    check_out();
  endtask

  function automatic logic [W-1:0] rnd_op();
    return {1'b1, F'($urandom)};
  endfunction

  initial begin
    logic [W-1:0] a;
    // R6: reset with valid held high, then release
    vtag = "R6";
    for (int i = 0; i < 3; i++) step(1'b1, rnd_op(), rnd_op(), "R2", 1'b1);
    for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, "R2", 1'b0);

    // R3: exact quotients
    vtag = "R4";
    step(1'b1, W'(1) << F, W'(1) << F, "R3", 1'b0);
    step(1'b1, {W{1'b1}}, W'(1) << F, "R3", 1'b0);
    for (int i = 0; i < 40; i++) begin
      a = rnd_op();
      step(1'b1, a, a, "R3", 1'b0);
      step(1'b1, rnd_op(), W'(1) << F, "R3", 1'b0);
    end

    // R2 / R4: back-to-back random stream
    for (int i = 0; i < 3000; i++) step(1'b1, rnd_op(), rnd_op(), "R2", 1'b0);
    step(1'b1, {W{1'b1}}, {W{1'b1}}, "R3", 1'b0);
    step(1'b1, W'(1) << F, {W{1'b1}}, "R2", 1'b0);
    step(1'b1, {W{1'b1}}, (W'(1) << F) + W'(1), "R2", 1'b0);

    // R7: both ends of every divisor segment
    for (int s = 0; s < (1 << M); s++) begin
      step(1'b1, {W{1'b1}}, {1'b1, M'(s), {(M-1){1'b0}}}, "R7", 1'b0);
      step(1'b1, W'(1) << F, {1'b1, M'(s), {(M-1){1'b1}}}, "R7", 1'b0);
      step(1'b1, rnd_op(), {1'b1, M'(s), {(M-1){1'b0}}}, "R7", 1'b0);
      step(1'b1, rnd_op(), {1'b1, M'(s), {(M-1){1'b1}}}, "R7", 1'b0);
    end

    // R5: gaps in the input stream
    vtag = "R5";
    for (int i = 0; i < 400; i++) step(1'($urandom), rnd_op(), rnd_op(), "R2", 1'b0);
    for (int i = 0; i < 20; i++) begin
      step(1'b1, rnd_op(), rnd_op(), "R2", 1'b0);
      step(1'b0, rnd_op(), rnd_op(), "R2", 1'b0);
    end

    // R6: reset in the middle of a stream
    vtag = "R6";
    for (int i = 0; i < 3; i++) step(1'b1, rnd_op(), rnd_op(), "R2", 1'b0);
    step(1'b1, rnd_op(), rnd_op(), "R2", 1'b1);
    for (int i = 0; i < LAT + 1; i++) step(1'b0, rnd_op(), rnd_op(), "R2", 1'b0);
    vtag = "R4";
    for (int i = 0; i < 10; i++) step(1'b1, rnd_op(), rnd_op(), "R2", 1'b0);
    for (int i = 0; i < LAT + 1; i++) step(1'b0, '0, '0, "R2", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R4 watchdog: actual run beyond %0d cycles expected to end earlier", 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule